// File: doc/BRIEF.md
# Two-Line Interrupt Source Identifier

This block keeps one interrupt-pending flag per message object, plus a single status-interrupt flag. It reports the most urgent pending source on each of two interrupt lines. Each object is sent to line 0 or line 1 by one bit in a routing bitmap. A read-only identifier word tells the interrupt handler which source is pending on each line: the low half is for line 0 and the high half is for line 1.

The acceptance logic outside the block sets flags by pulsing one bit per object. A handler acknowledges an object in two steps. First it writes the clear-pending command code into the command register. Then it writes the object number, and that write performs the clear. The status flag clears when software reads the status register. Objects are numbered from 1, and the value 0 in an identifier field means that nothing is pending on that line.

Top module: `irq_source_id`

## Requirements
- R1: After reset, no flag is pending, every routing bit is 0, the command register holds 0, `int_id` is 0 and both `int_line` bits are low.
- R2: A high `set_vec[k]` at a clock edge makes object k+1 pending, and the object is reported from the next cycle on.
- R3: `int_id[15:0]` gives the lowest-numbered pending object routed to line 0. `int_id[31:16]` gives the lowest-numbered pending object routed to line 1.
- R4: The routing bitmap is written one 32-bit word at a time through `route_sel`. Bit b of word w belongs to object 32*w+b, and a value of 1 sends that object to line 1. Bit 0 of word 0 and bits above `NUM_OBJ` are ignored.
- R5: While the status flag is pending, `int_id[15:0]` reads 16'h8000 whatever objects are pending. `int_id[31:16]` is not affected.
- R6: `status_set` raises the status flag and `status_rd` clears it. If both arrive in the same cycle, the flag stays set.
- R7: A `num_wr` of object n clears n's flag only if the command register already holds 8'h08 before that edge. It has no effect for any other command value, for n = 0, or for n > `NUM_OBJ`.
- R8: If a clear and a `set_vec` pulse hit the same object in the same cycle, the object stays pending.
- R9: `int_line[k]` is high only while `line_en[k]` is high and identifier field k is nonzero. A disabled line stays low, but its identifier field keeps updating.
- R10: An identifier field reads 0 when nothing is pending on its line, and a line-1 field never exceeds `NUM_OBJ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vec | input | NUM_OBJ | Set pulses; bit k is for object k+1 |
| status_set | input | 1 | Status interrupt event |
| status_rd | input | 1 | Status register read; clears the status flag |
| route_we | input | 1 | Routing word write strobe |
| route_sel | input | SW | Routing word index |
| route_wdata | input | 32 | Routing word data |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command value |
| num_wr | input | 1 | Object number write; triggers the stored command |
| num_wdata | input | 8 | Object number |
| line_en | input | 2 | Per-line output enable |
| int_id | output | 32 | Line 1 identifier in [31:16], line 0 identifier in [15:0] |
| int_line | output | 2 | Interrupt lines |

## Verification
The bench builds the block with `NUM_OBJ` = 40, so the routing bitmap has two words. Objects 32 through 40 sit in word 1, which brings the word-to-object mapping and the cross-word lowest-number search within reach. It also makes clear numbers above the object range, from 41 to 43, reachable with random object numbers. With only 40 objects, random sparse sets collide often with clears, status events and routing rewrites, so same-cycle set/clear and status pre-emption occur many times.

// File: rtl/irq_source_id.sv
module irq_source_id #(
  parameter int          NUM_OBJ     = 40,
  parameter logic [7:0]  CLR_CMD     = 8'h08,
  parameter logic [15:0] STATUS_CODE = 16'h8000,
  localparam int RW = (NUM_OBJ + 32) / 32,
  localparam int SW = (RW > 1) ? $clog2(RW) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] set_vec,
  input  logic               status_set,
  input  logic               status_rd,
  input  logic               route_we,
  input  logic [SW-1:0]      route_sel,
  input  logic [31:0]        route_wdata,
  input  logic               cmd_wr,
  input  logic [7:0]         cmd_wdata,
  input  logic               num_wr,
  input  logic [7:0]         num_wdata,
  input  logic [1:0]         line_en,
  output logic [31:0]        int_id,
  output logic [1:0]         int_line
);

  logic [NUM_OBJ:1] pend_q;
  logic [NUM_OBJ:1] route_q;
  logic [7:0]       cmd_q;
  logic             stat_q;
  logic             clr_hit;
  logic [15:0]      id0, id1;

  assign clr_hit = num_wr && (cmd_q == CLR_CMD) &&
                   (num_wdata != 8'd0) && (num_wdata <= 8'(NUM_OBJ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= cmd_wdata;
      stat_q <= status_set | (stat_q & ~status_rd);
    end
  end

  for (genvar i = 1; i <= NUM_OBJ; i++) begin : g_obj
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i]  <= 1'b0;
        route_q[i] <= 1'b0;
      end else begin
        pend_q[i] <= set_vec[i-1] |
                     (pend_q[i] & ~(clr_hit && (num_wdata == 8'(i))));
        if (route_we && (route_sel == SW'(i / 32)))
          route_q[i] <= route_wdata[i % 32];
      end
    end
  end

  always_comb begin
    id0 = '0;
    id1 = '0;
    for (int i = NUM_OBJ; i >= 1; i--) begin
      if (pend_q[i]) begin
        if (route_q[i]) id1 = 16'(i);
        else            id0 = 16'(i);
      end
    end
    if (stat_q) id0 = STATUS_CODE;
  end

  assign int_id   = {id1, id0};
  assign int_line = {line_en[1] && (id1 != '0), line_en[0] && (id0 != '0)};

endmodule

// File: rtl/irq_source_id_chk.sv
module irq_source_id_chk #(
  parameter int NUM_OBJ = 40,
  localparam int RW = (NUM_OBJ + 32) / 32,
  localparam int SW = (RW > 1) ? $clog2(RW) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OBJ-1:0] set_vec,
  input logic               status_set,
  input logic               status_rd,
  input logic [1:0]         line_en,
  input logic [31:0]        int_id,
  input logic [1:0]         int_line
);

  AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> (int_id[15:0] == 16'd1 || int_id[15:0] == 16'h8000 || int_id[31:16] == 16'd1)); // R2

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status_set |=> int_id[15:0] == 16'h8000); // R5

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !status_set) |=> int_id[15:0] != 16'h8000); // R6

  AST_LINE0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en[0] |-> !int_line[0]); // R9

  AST_LINE1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en[1] |-> !int_line[1]); // R9

  AST_LINE1_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    int_line[1] |-> int_id[31:16] != 16'd0); // R10

  AST_ID1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int_id[31:16] <= 16'(NUM_OBJ)); // R10

endmodule

bind irq_source_id irq_source_id_chk #(.NUM_OBJ(NUM_OBJ)) chk_i (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .status_set(status_set),
  .status_rd(status_rd), .line_en(line_en), .int_id(int_id), .int_line(int_line));

// File: tb/irq_source_id_tb_top.sv
`timescale 1ns/1ps
module irq_source_id_tb_top;
  localparam int NUM = 40;
  localparam int SW  = 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NUM-1:0] set_vec = '0;
  logic           status_set = 1'b0, status_rd = 1'b0;
  logic           route_we = 1'b0;
  logic [SW-1:0]  route_sel = '0;
  logic [31:0]    route_wdata = '0;
  logic           cmd_wr = 1'b0, num_wr = 1'b0;
  logic [7:0]     cmd_wdata = '0, num_wdata = '0;
  logic [1:0]     line_en = 2'b11;
  logic [31:0]    int_id;
  logic [1:0]     int_line;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [NUM:1] m_pend = '0, m_route = '0;
  logic [7:0]   m_cmd = '0;
  logic         m_stat = 1'b0;

  irq_source_id #(.NUM_OBJ(NUM)) dut_i (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_field(input int line);
    if (line == 0 && m_stat) return 16'h8000;
    for (int o = 1; o <= NUM; o++)
      if (m_pend[o] && (int'(m_route[o]) == line)) return 16'(o);
    return 16'd0;
  endfunction

  task automatic compare_model();
    logic [15:0] e0, e1;
    e0 = exp_field(0);
    e1 = exp_field(1);
    check("R3/R5 line0 id", {16'd0, int_id[15:0]}, {16'd0, e0});
    check("R3/R4 line1 id", {16'd0, int_id[31:16]}, {16'd0, e1});
    check("R9 lines", {30'd0, int_line},
          {30'd0, line_en[1] && e1 != 0, line_en[0] && e0 != 0});
  endtask

  task automatic tick();
    logic hit;
    hit = num_wr && m_cmd == 8'h08 && num_wdata >= 8'd1 && num_wdata <= 8'(NUM);
    for (int o = 1; o <= NUM; o++)
      m_pend[o] = set_vec[o-1] | (m_pend[o] & !(hit && num_wdata == 8'(o)));
    if (route_we)
      for (int b = 0; b < 32; b++) begin
        int o = 32 * int'(route_sel) + b;
        if (o >= 1 && o <= NUM) m_route[o] = route_wdata[b];
      end
    m_stat = status_set | (m_stat & !status_rd);
    if (cmd_wr) m_cmd = cmd_wdata;
    @(negedge clk);
    compare_model();
    set_vec = '0; status_set = 0; status_rd = 0; route_we = 0; cmd_wr = 0; num_wr = 0;
  endtask

  task automatic do_clear(input logic [7:0] cmd, input logic [7:0] n);
    cmd_wr = 1; cmd_wdata = cmd; tick();
    num_wr = 1; num_wdata = n; tick();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    check("R1 id after reset", int_id, 32'd0);
    check("R1 lines after reset", {30'd0, int_line}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 nothing pending", int_id, 32'd0);

    set_vec[0] = 1; set_vec[4] = 1; tick();
    check("R2/R3 object 1 lowest", {16'd0, int_id[15:0]}, 32'd1);
    do_clear(8'h08, 8'd1);
    check("R7 clear object 1", {16'd0, int_id[15:0]}, 32'd5);

    route_we = 1; route_sel = 1'b1; route_wdata = 32'h0000_0002; tick();
    set_vec[32] = 1; tick();
    check("R4 object 33 on line 1", {16'd0, int_id[31:16]}, 32'd33);

    status_set = 1; tick();
    check("R5 status code", {16'd0, int_id[15:0]}, 32'h8000);
    check("R5 line1 unaffected", {16'd0, int_id[31:16]}, 32'd33);
    status_set = 1; status_rd = 1; tick();
    check("R6 set wins over read", {16'd0, int_id[15:0]}, 32'h8000);
    status_rd = 1; tick();
    check("R6 read clears", {16'd0, int_id[15:0]}, 32'd5);

    do_clear(8'h09, 8'd5);
    check("R7 wrong command ignored", {16'd0, int_id[15:0]}, 32'd5);
    do_clear(8'h08, 8'd0);
    check("R7 number 0 ignored", {16'd0, int_id[15:0]}, 32'd5);
    num_wr = 1; num_wdata = 8'd41; tick();
    check("R7 out of range ignored", int_id, {16'd33, 16'd5});

    num_wr = 1; num_wdata = 8'd5; set_vec[4] = 1; tick();
    check("R8 same-cycle set wins", {16'd0, int_id[15:0]}, 32'd5);

    line_en = 2'b10; tick();
    check("R9 disabled line low", {31'd0, int_line[0]}, 32'd0);
    set_vec[1] = 1; tick();
    check("R9 id updates while disabled", {16'd0, int_id[15:0]}, 32'd2);
    line_en = 2'b11;

    for (int c = 0; c < 3000; c++) begin
      for (int k = 0; k < NUM; k++) set_vec[k] = ($urandom % 24) == 0;
      status_set = ($urandom % 16) == 0;
      status_rd  = ($urandom % 8) == 0;
      route_we   = ($urandom % 20) == 0;
      route_sel  = SW'($urandom % 2);
      route_wdata = $urandom;
      cmd_wr     = ($urandom % 4) == 0;
      cmd_wdata  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h08;
      num_wr     = ($urandom % 2) == 0;
      num_wdata  = 8'($urandom % (NUM + 4));
      if (($urandom % 50) == 0) line_en = 2'($urandom);
      tick();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule